// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a data cache that sits between a load/store unit and a lower-level memory. It holds 8 KB as 256 lines of 32 bytes each, one possible slot per memory block, on a 34-bit physical byte address. The CPU side offers one load or store at a time through a valid/ready handshake. Loads that hit are answered on the next cycle. Loads that miss bring the whole 32-byte line in from memory before the requested word is returned.

Every store travels toward memory through a four-entry FIFO write buffer. Store latency is therefore hidden unless that buffer is full. A store that hits also refreshes the cached word. A store that misses leaves the cache untouched, so no line is allocated on a write.

The memory side has a single request channel with its own valid/ready handshake. That channel carries buffered word writes and line-read requests, and read data comes back as one whole line on a separate response strobe.

Top module: `dcwt_cache`

## Requirements
- R1: The byte address splits into bits [4:0] as the offset within a line, bits [12:5] as the line index and bits [33:13] as the tag. A block can live only in the line whose index is its block address modulo 256, so two addresses 8 KB apart evict each other.
- R2: After the synchronous active-high reset, every line is invalid. cpu_req_ready is high, cpu_rsp_valid is low and mem_req_valid is low.
- R3: An accepted load whose line is valid and whose stored tag equals the address tag returns, in the following cycle, the 32-bit word selected by address bits [4:2]. It causes no memory read.
- R4: An accepted load that misses issues one read request with mem_req_write low, addressed to the line base (bits [4:0] zero). The response carries the word at byte offset 4*i in mem_rsp_line bits [32*i+31:32*i]. The cycle after mem_rsp_valid, the cache returns the requested word and marks the line valid under the new tag, so a repeat load hits.
- R5: Before a miss issues its line read, every buffered store whose address falls in the same line has been written to memory. The fill therefore returns the stored data.
- R6: Every accepted store is sent to memory as a write request with mem_req_write high, carrying the store's address and data. Stores are whole 32-bit words; memory treats address bits [1:0] as zero.
- R7: A store that hits updates the cached word, and a following load to that word returns the new data without a memory read.
- R8: A store that misses does not allocate. A later load to that line still misses and fetches from memory.
- R9: The write buffer holds four stores. A store is accepted in one cycle while an entry is free. With four entries pending, a store is held with cpu_req_ready low until one entry drains.
- R10: Buffered stores reach memory in the order they were accepted, one per memory handshake.
- R11: While mem_req_valid is high and mem_req_ready is low, the request stays asserted with unchanged address and direction.
- R12: While a miss is being served, cpu_req_ready stays low, so only one miss is ever outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Cache accepts the CPU request this cycle |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 34 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_rdata | output | 32 | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = word write, 0 = line read |
| mem_req_addr | output | 34 | Write address or line base address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Line read data valid |
| mem_rsp_line | input | 256 | Returned line, word i at bits [32i+31:32i] |

## Verification
The hardest case to reach is a load miss to a line that still has an undrained store sitting in the write buffer. That case needs a store miss to be queued and then held back from memory while the load arrives. The stimulus gets there by forcing memory-side ready low before the store, issuing the load to the same word, and releasing memory only after the cache has entered its drain wait. A wrong drain ordering then shows up as the old memory word coming back. The full-buffer stall is reached in the same way: memory is stalled while five stores are offered back to back.

// File: rtl/dcwt_pkg.sv
package dcwt_pkg;
    localparam int ADDR_W     = 34;
    localparam int LINE_BYTES = 32;
    localparam int NUM_LINES  = 256;
    localparam int WORD_W     = 32;
    localparam int WB_DEPTH   = 4;

    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
    localparam int BLK_W      = ADDR_W - OFF_W;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int BSEL_W     = $clog2(WORD_BYTES);
    localparam int WSEL_W     = OFF_W - BSEL_W;
    localparam int LINE_W     = LINE_BYTES * 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_FETCH,
        ST_WAIT
    } ctl_state_t;

    function automatic logic [WORD_W-1:0] pick_word(
        input logic [LINE_W-1:0] line,
        input logic [WSEL_W-1:0] sel
    );
        return line[WORD_W*int'(sel) +: WORD_W];
    endfunction
endpackage

// File: rtl/dcwt_store.sv
module dcwt_store
    import dcwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line
);
    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q  [NUM_LINES];
    logic [LINE_W-1:0]    data_q [NUM_LINES];

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_line  = data_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_tag;
            data_q[fill_idx] <= fill_line;
        end else if (wr_en) begin
            data_q[wr_idx][WORD_W*int'(wr_wsel) +: WORD_W] <= wr_word;
        end
    end

    // R4: a fill leaves its line valid
    p_fill_sets_valid_r4: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> valid_q[$past(fill_idx)]);
endmodule

// File: rtl/dcwt_wbuf.sv
module dcwt_wbuf
    import dcwt_pkg::*;
#(
    parameter int DEPTH = WB_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  wb_entry_t        push_entry,
    input  logic             pop,
    output wb_entry_t        head,
    output logic             empty,
    output logic             full,
    input  logic [BLK_W-1:0] probe_blk,
    output logic             probe_hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    wb_entry_t        slot_q [DEPTH];
    logic [DEPTH-1:0] occ_q;
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic [DEPTH-1:0] match_v;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign head  = slot_q[rd_ptr_q];
    assign empty = (count_q == '0);
    assign full  = (count_q == CNT_W'(DEPTH));

    for (genvar i = 0; i < DEPTH; i++) begin : g_probe
        assign match_v[i] = occ_q[i] && (slot_q[i].addr[ADDR_W-1:OFF_W] == probe_blk);
    end
    assign probe_hit = |match_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q    <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) begin
                slot_q[wr_ptr_q] <= push_entry;
                occ_q[wr_ptr_q]  <= 1'b1;
                wr_ptr_q         <= step(wr_ptr_q);
            end
            if (pop) begin
                occ_q[rd_ptr_q] <= 1'b0;
                rd_ptr_q        <= step(rd_ptr_q);
            end
            if (push && !pop)      count_q <= count_q + CNT_W'(1);
            else if (pop && !push) count_q <= count_q - CNT_W'(1);
        end
    end

    p_no_push_full_r9: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    p_count_grows_r9: assert property (@(posedge clk) disable iff (rst)
        push && !pop |=> count_q == $past(count_q) + CNT_W'(1));
    p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    p_occ_count_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(occ_q) == int'(count_q));
endmodule

// File: rtl/dcwt_cache.sv
module dcwt_cache
    import dcwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [WORD_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [WORD_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_line
);
    ctl_state_t        state_q;
    logic [BLK_W-1:0]  miss_blk_q;
    logic [WSEL_W-1:0] miss_wsel_q;
    logic              rsp_valid_q;
    logic [WORD_W-1:0] rsp_data_q;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WSEL_W-1:0] req_wsel;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid;
    logic [LINE_W-1:0] rd_line;
    logic              lookup_hit, accept, ld_acc, st_acc, fill_en;
    logic              wb_full, wb_empty, wb_pop, wb_match;
    wb_entry_t         wb_in, wb_head;

    assign req_idx  = cpu_req_addr[OFF_W +: IDX_W];
    assign req_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign req_wsel = cpu_req_addr[OFF_W-1:BSEL_W];

    assign lookup_hit    = rd_valid && (rd_tag == req_tag);
    assign cpu_req_ready = (state_q == ST_IDLE) && (!cpu_req_write || !wb_full);
    assign accept        = cpu_req_valid && cpu_req_ready;
    assign ld_acc        = accept && !cpu_req_write;
    assign st_acc        = accept && cpu_req_write;
    assign fill_en       = (state_q == ST_WAIT) && mem_rsp_valid;
    assign wb_in         = '{addr: cpu_req_addr, data: cpu_req_wdata};

    dcwt_store u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (req_idx),
        .rd_tag    (rd_tag),
        .rd_valid  (rd_valid),
        .rd_line   (rd_line),
        .wr_en     (st_acc && lookup_hit),
        .wr_idx    (req_idx),
        .wr_wsel   (req_wsel),
        .wr_word   (cpu_req_wdata),
        .fill_en   (fill_en),
        .fill_idx  (miss_blk_q[IDX_W-1:0]),
        .fill_tag  (miss_blk_q[BLK_W-1:IDX_W]),
        .fill_line (mem_rsp_line)
    );

    dcwt_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
        .clk        (clk),
        .rst        (rst),
        .push       (st_acc),
        .push_entry (wb_in),
        .pop        (wb_pop),
        .head       (wb_head),
        .empty      (wb_empty),
        .full       (wb_full),
        .probe_blk  (miss_blk_q),
        .probe_hit  (wb_match)
    );

    // one request channel: line reads own it in FETCH, buffer drains otherwise
    assign mem_req_valid = (state_q == ST_FETCH) ||
                           (((state_q == ST_IDLE) || (state_q == ST_DRAIN)) && !wb_empty);
    assign mem_req_write = (state_q != ST_FETCH);
    assign mem_req_addr  = (state_q == ST_FETCH) ? {miss_blk_q, {OFF_W{1'b0}}} : wb_head.addr;
    assign mem_req_wdata = wb_head.data;
    assign wb_pop        = mem_req_valid && mem_req_ready && mem_req_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            miss_blk_q  <= '0;
            miss_wsel_q <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (ld_acc && lookup_hit) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= pick_word(rd_line, req_wsel);
                    end else if (ld_acc) begin
                        miss_blk_q  <= cpu_req_addr[ADDR_W-1:OFF_W];
                        miss_wsel_q <= req_wsel;
                        state_q     <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (!wb_match && (wb_empty || mem_req_ready)) state_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= pick_word(mem_rsp_line, miss_wsel_q);
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_rsp_valid = rsp_valid_q;
    assign cpu_rsp_rdata = rsp_data_q;

    p_fetch_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_write |-> mem_req_addr[OFF_W-1:0] == '0);
    p_fill_answers_r4: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> cpu_rsp_valid);
    p_fetch_after_drain_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_write |-> !wb_match);
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));
    p_busy_blocks_r12: assert property (@(posedge clk) disable iff (rst)
        ld_acc && !lookup_hit |=> !cpu_req_ready);
endmodule

// File: tb/dcwt_cache_tb.sv
module dcwt_cache_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_req_valid = 1'b0;
    logic         cpu_req_ready;
    logic         cpu_req_write = 1'b0;
    logic [33:0]  cpu_req_addr = '0;
    logic [31:0]  cpu_req_wdata = '0;
    logic         cpu_rsp_valid;
    logic [31:0]  cpu_rsp_rdata;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic         mem_req_write;
    logic [33:0]  mem_req_addr;
    logic [31:0]  mem_req_wdata;
    logic         mem_rsp_valid = 1'b0;
    logic [255:0] mem_rsp_line = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcwt_cache u_dut (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line)
    );

    int total = 0;
    int bad = 0;
    int n_rd = 0;
    int n_wr = 0;
    int hold_err = 0;
    logic [31:0] mem_w [logic [33:0]];
    logic [31:0] wlog [$];
    logic        mem_stall = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic        pend = 1'b0;
    int          rd_cnt = 0;
    logic [33:0] rd_base = '0;
    logic        prev_wait = 1'b0;
    logic [33:0] prev_addr = '0;
    logic        prev_we = 1'b0;

    function automatic logic [31:0] model_word(input logic [33:0] a);
        logic [33:0] aa;
        aa = {a[33:2], 2'b00};
        if (mem_w.exists(aa)) return mem_w[aa];
        return aa[31:0] ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [255:0] build_line(input logic [33:0] base);
        logic [255:0] l;
        for (int i = 0; i < 8; i++) l[32*i +: 32] = model_word(base + 34'(4*i));
        return l;
    endfunction

    // memory model: drives at the falling edge, logs the handshake of the next rising edge
    initial begin : mem_model
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend && rd_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_line  = build_line(rd_base);
                pend = 1'b0;
            end else if (pend) begin
                rd_cnt--;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_req_ready = !mem_stall && (lfsr[0] || lfsr[1]);
            #1;
            if (rst) begin
                prev_wait = 1'b0;
            end else begin
                if (prev_wait && !(mem_req_valid === 1'b1 && mem_req_addr == prev_addr &&
                                   mem_req_write == prev_we)) hold_err++;
                prev_wait = (mem_req_valid === 1'b1) && !mem_req_ready;
                prev_addr = mem_req_addr;
                prev_we   = mem_req_write;
                if (mem_req_valid === 1'b1 && mem_req_ready) begin
                    if (mem_req_write) begin
                        mem_w[{mem_req_addr[33:2], 2'b00}] = mem_req_wdata;
                        wlog.push_back(mem_req_wdata);
                        n_wr++;
                    end else begin
                        pend = 1'b1;
                        rd_cnt = 2;
                        rd_base = mem_req_addr;
                        n_rd++;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cpu_req_valid = 1'b0;
        pend = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cpu_load(input logic [33:0] a, output logic [31:0] d, output int lat);
        int t;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = a;
        t = 0;
        #2;
        while (!cpu_req_ready && t < 1000) begin @(negedge clk); #2; t++; end
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 1;
        while (!cpu_rsp_valid && lat < 1000) begin @(negedge clk); lat++; end
        d = cpu_rsp_rdata;
    endtask

    task automatic cpu_store(input logic [33:0] a, input logic [31:0] d, output int waits);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = a; cpu_req_wdata = d;
        waits = 0;
        #2;
        while (!cpu_req_ready && waits < 1000) begin @(negedge clk); #2; waits++; end
        @(negedge clk);
        cpu_req_valid = 1'b0;
        cpu_req_write = 1'b0;
    endtask

    task automatic wait_drain();
        repeat (40) @(negedge clk);
    endtask

    localparam logic [33:0] A0 = 34'h0_0000_1000;

    task automatic t_reset();
        @(negedge clk); #2;
        chk(cpu_req_ready === 1'b1, "R2 ready after reset", 64'(cpu_req_ready), 1);
        chk(cpu_rsp_valid === 1'b0, "R2 no response after reset", 64'(cpu_rsp_valid), 0);
        chk(mem_req_valid === 1'b0, "R2 no memory request after reset", 64'(mem_req_valid), 0);
    endtask

    task automatic t_miss();
        logic [31:0] d; int lat; int n0;
        n0 = n_rd;
        cpu_load(A0 + 34'h8, d, lat);
        chk(d == model_word(A0 + 34'h8), "R4 miss data", 64'(d), 64'(model_word(A0 + 34'h8)));
        chk(n_rd == n0 + 1, "R4 one line read", 64'(n_rd), 64'(n0 + 1));
        chk(rd_base == A0, "R1 line base address", 64'(rd_base), 64'(A0));
    endtask

    task automatic t_hit();
        logic [31:0] d; int lat; int n0;
        n0 = n_rd;
        cpu_load(A0 + 34'h1C, d, lat);
        chk(d == model_word(A0 + 34'h1C), "R3 hit data", 64'(d), 64'(model_word(A0 + 34'h1C)));
        chk(lat == 1, "R3 hit latency", 64'(lat), 1);
        chk(n_rd == n0, "R3 no memory read", 64'(n_rd), 64'(n0));
    endtask

    task automatic t_store_hit();
        logic [31:0] d; int lat; int w; int n0;
        n0 = n_rd;
        cpu_store(A0 + 34'h4, 32'hCAFE_0004, w);
        cpu_load(A0 + 34'h4, d, lat);
        chk(d == 32'hCAFE_0004, "R7 store hit updates line", 64'(d), 64'h00000000CAFE0004);
        chk(lat == 1 && n_rd == n0, "R7 served as hit", 64'(lat), 1);
        wait_drain();
        chk(model_word(A0 + 34'h4) == 32'hCAFE_0004, "R6 write-through reached memory",
            64'(model_word(A0 + 34'h4)), 64'h00000000CAFE0004);
    endtask

    task automatic t_store_miss();
        logic [31:0] d; int lat; int w; int n0;
        logic [33:0] c;
        c = 34'h3_0000_0048;
        mem_stall = 1'b1;
        repeat (2) @(negedge clk);
        cpu_store(c, 32'h1357_9BDF, w);
        n0 = n_rd;
        fork
            cpu_load(c, d, lat);
            begin
                repeat (4) @(negedge clk);
                #2;
                chk(cpu_req_ready == 1'b0, "R12 no accept during miss", 64'(cpu_req_ready), 0);
                chk(n_rd == n0, "R5 no read while store pending", 64'(n_rd), 64'(n0));
                mem_stall = 1'b0;
            end
        join
        chk(d == 32'h1357_9BDF, "R5 fill sees drained store", 64'(d), 64'h0000000013579BDF);
        chk(n_rd == n0 + 1, "R8 store miss did not allocate", 64'(n_rd), 64'(n0 + 1));
        n0 = n_rd;
        cpu_load(c, d, lat);
        chk(lat == 1 && n_rd == n0, "R4 filled line now hits", 64'(lat), 1);
    endtask

    task automatic t_conflict();
        logic [31:0] d; int lat; int n0;
        n0 = n_rd;
        cpu_load(A0 + 34'h2000, d, lat);
        chk(d == model_word(A0 + 34'h2000), "R1 conflict line data", 64'(d), 64'(model_word(A0 + 34'h2000)));
        cpu_load(A0, d, lat);
        chk(n_rd == n0 + 2, "R1 same index evicts", 64'(n_rd), 64'(n0 + 2));
        chk(d == model_word(A0), "R1 refetched data", 64'(d), 64'(model_word(A0)));
    endtask

    task automatic t_full();
        int w; int w5; int n0;
        wait_drain();
        n0 = n_wr;
        mem_stall = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            cpu_store(34'h5000 + 34'(4*i), 32'hF000_0000 + 32'(i), w);
            chk(w == 0, "R9 store accepted while entry free", 64'(w), 0);
        end
        fork
            cpu_store(34'h5010, 32'hF000_0004, w5);
            begin
                repeat (3) @(negedge clk);
                #2;
                chk(cpu_req_ready == 1'b0, "R9 full buffer stalls store", 64'(cpu_req_ready), 0);
                mem_stall = 1'b0;
            end
        join
        chk(w5 >= 3, "R9 stall length", 64'(w5), 3);
        wait_drain();
        chk(n_wr == n0 + 5, "R6 every store written", 64'(n_wr), 64'(n0 + 5));
    endtask

    task automatic t_fifo();
        int w; int n;
        wait_drain();
        mem_stall = 1'b1;
        repeat (2) @(negedge clk);
        cpu_store(34'h7000, 32'h0000_00D1, w);
        cpu_store(34'h7000, 32'h0000_00D2, w);
        cpu_store(34'h7000, 32'h0000_00D3, w);
        mem_stall = 1'b0;
        wait_drain();
        n = wlog.size();
        chk(n >= 3 && wlog[n-3] == 32'hD1 && wlog[n-2] == 32'hD2 && wlog[n-1] == 32'hD3,
            "R10 drain order", 64'(wlog[n-1]), 64'hD3);
        chk(model_word(34'h7000) == 32'hD3, "R10 last store wins", 64'(model_word(34'h7000)), 64'hD3);
    endtask

    task automatic t_reset_clear();
        logic [31:0] d; int lat; int n0;
        cpu_load(A0, d, lat);
        do_reset();
        n0 = n_rd;
        cpu_load(A0, d, lat);
        chk(n_rd == n0 + 1, "R2 reset invalidates lines", 64'(n_rd), 64'(n0 + 1));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        do_reset();
        t_reset();
        t_miss();
        t_hit();
        t_store_hit();
        t_store_miss();
        t_conflict();
        t_full();
        t_fifo();
        t_reset_clear();
        chk(hold_err == 0, "R11 request held while not ready", 64'(hold_err), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule